// File: doc/BRIEF.md
# Folded SRAM Access Sequencer

This block models a single-port static memory of 2048 sixteen-bit words. The words are not stored one per row. The storage is a physical grid of 256 rows by 128 bit columns, with eight words sharing each row. A controller takes every request through a fixed series of array phases:

- bitline conditioning;
- a wordline pulse held long enough for the bitlines to swing;
- a sense strobe;
- a result cycle.

Sixteen eight-way column selectors pick the addressed word from the 128 sensed columns.

A client drives `req` with `we`, `addr` and `wdata` while `ready` is high. The request is taken on that clock edge. `ready` then stays low until the access has finished. Completion is marked by a single-cycle `rvalid` pulse with the word on `rdata`. For a write, `rdata` carries the word that was just stored. The number of wordline cycles is the parameter `WL_CYCLES`.

Top module: `sram_fold_seq`

## Requirements
- R1: While reset is held and on the cycle after it, `ready` is 1 and `rvalid` is 0.
- R2: The address splits into two fields. `addr[2:0]` selects one of the eight column groups, and `addr[10:3]` selects one of the 256 rows. Each of the 2048 addresses holds its own independent word.
- R3: A write stores `wdata` at `addr`. Its completion shows the written word on `rdata`, and a later read of that address returns it.
- R4: Accepting a request is followed by these phases:
  - one conditioning cycle;
  - `WL_CYCLES` wordline cycles;
  - one sense cycle;
  - a result cycle in which `rvalid` is 1.

  Counting the acceptance cycle as cycle 0, `rvalid` is high in cycle `WL_CYCLES+3` only and low in the cycle after it.
- R5: A request is accepted only in a cycle in which `ready` is 1. `ready` is 0 from the cycle after acceptance through the `rvalid` cycle. Requests presented while `ready` is 0 are ignored and change no stored word.
- R6: A write changes only the 16 columns of the addressed word. The other seven words in the same row keep their values.
- R7: During the wordline phase exactly one wordline is high. In every other phase, including conditioning, no wordline is high.
- R8: For a read, both bitlines of every column are high when the wordline rises.
- R9: The sense strobe fires only after the wordline has been high for at least `WL_CYCLES` cycles of the current access.
- R10: The row is decoded through two predecoded one-hot groups, one from each half of the row field, that are combined into the wordlines. Every one of the 256 rows is reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request; taken on an edge where `ready` is 1 |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 11 | Word address: row field above, column-group field in the low three bits |
| wdata | input | 16 | Word to store on a write |
| ready | output | 1 | Controller idle and able to take a request |
| rvalid | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Sensed word, valid while `rvalid` is 1 |

## Verification
The bench first fills the whole array with an arithmetic pattern and reads every address back. A design that swapped the row and column fields, misrouted a column selector or merged two predecoded rows would return a neighbour's word. It then rewrites a single word and reads its seven row-mates. A write that lands on the whole row, or that leaves the undriven columns precharged into the cells, would corrupt those row-mates. A write is also held on the request pins while an access is in flight. A controller that accepted work outside idle would overwrite the poked address. Every access also has its completion cycle timed, which exposes a phase that is skipped or stretched and an `rvalid` held for more than one cycle.

// File: rtl/sram_fold_pkg.sv
`timescale 1ns/1ps
package sram_fold_pkg;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 11;
    localparam int COL_SEL_W = 3;

    localparam int ROW_W    = ADDR_W - COL_SEL_W;
    localparam int MUX_WAYS = 1 << COL_SEL_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int COLS     = WORD_W * MUX_WAYS;
    localparam int PRE_LO_W = ROW_W / 2;
    localparam int PRE_HI_W = ROW_W - PRE_LO_W;
    localparam int PRE_LO_N = 1 << PRE_LO_W;
    localparam int PRE_HI_N = 1 << PRE_HI_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COND,
        PH_WORDL,
        PH_SENSE,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic                 we;
        logic [ROW_W-1:0]     row;
        logic [COL_SEL_W-1:0] col;
        logic [WORD_W-1:0]    data;
    } access_t;

    // Bit b of a word lives in physical column b*MUX_WAYS + group.
    function automatic logic [COLS-1:0] group_mask(input logic [COL_SEL_W-1:0] grp);
        logic [COLS-1:0] m;
        m = '0;
        for (int b = 0; b < WORD_W; b++) m[b*MUX_WAYS + int'(grp)] = 1'b1;
        return m;
    endfunction

    function automatic logic [COLS-1:0] spread_word(input logic [WORD_W-1:0] d,
                                                    input logic [COL_SEL_W-1:0] grp);
        logic [COLS-1:0] v;
        v = '0;
        for (int b = 0; b < WORD_W; b++) v[b*MUX_WAYS + int'(grp)] = d[b];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] gather_word(input logic [COLS-1:0] lines,
                                                      input logic [COL_SEL_W-1:0] grp);
        logic [WORD_W-1:0] w;
        for (int b = 0; b < WORD_W; b++) w[b] = lines[b*MUX_WAYS + int'(grp)];
        return w;
    endfunction
endpackage

// File: rtl/sfa_row_predec.sv
`timescale 1ns/1ps
module sfa_row_predec
    import sram_fold_pkg::*;
(
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  wl
);
    logic [PRE_LO_N-1:0] grp_lo;
    logic [PRE_HI_N-1:0] grp_hi;

    always_comb begin
        grp_lo = '0;
        grp_hi = '0;
        grp_lo[row[PRE_LO_W-1:0]]     = en;
        grp_hi[row[ROW_W-1:PRE_LO_W]] = en;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        localparam int HI_IDX = r / PRE_LO_N;
        localparam int LO_IDX = r % PRE_LO_N;
        assign wl[r] = grp_hi[HI_IDX] & grp_lo[LO_IDX];
    end
endmodule

// File: rtl/sfa_phase_ctrl.sv
`timescale 1ns/1ps
module sfa_phase_ctrl
    import sram_fold_pkg::*;
#(
    parameter int WL_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    output phase_e phase,
    output logic   accept,
    output logic   cond_en,
    output logic   wl_en,
    output logic   sense_en,
    output logic   done
);
    localparam int CNT_W = $clog2(WL_CYCLES + 1);
    localparam logic [CNT_W-1:0] WL_LAST = CNT_W'(WL_CYCLES - 1);

    phase_e           state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PH_IDLE:  if (req) state_q <= PH_COND;
                PH_COND:  begin
                    state_q <= PH_WORDL;
                    cnt_q   <= '0;
                end
                PH_WORDL: begin
                    if (cnt_q == WL_LAST) state_q <= PH_SENSE;
                    else                  cnt_q   <= cnt_q + 1'b1;
                end
                PH_SENSE: state_q <= PH_DONE;
                PH_DONE:  state_q <= PH_IDLE;
                default:  state_q <= PH_IDLE;
            endcase
        end
    end

    assign phase    = state_q;
    assign accept   = (state_q == PH_IDLE) && req;
    assign cond_en  = (state_q == PH_COND);
    assign wl_en    = (state_q == PH_WORDL);
    assign sense_en = (state_q == PH_SENSE);
    assign done     = (state_q == PH_DONE);
endmodule

// File: rtl/sfa_bit_array.sv
`timescale 1ns/1ps
module sfa_bit_array
    import sram_fold_pkg::*;
#(
    parameter int WL_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cond_en,
    input  logic                 wr,
    input  logic [COL_SEL_W-1:0] col_sel,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [ROWS-1:0]      wl,
    input  logic                 sense_en,
    output logic [WORD_W-1:0]    rdata
);
    localparam int SW_W = $clog2(WL_CYCLES + 2);

    logic [COLS-1:0]   cells [ROWS];
    logic [COLS-1:0]   bl_q, blb_q;
    logic [COLS-1:0]   mask, drive, held, row_word;
    logic [WORD_W-1:0] sense_q;
    logic [SW_W-1:0]   swing_q;
    logic              wl_any, wl_any_q;

    assign mask   = group_mask(col_sel);
    assign drive  = spread_word(wdata, col_sel);
    assign held   = wr ? mask : '0;
    assign wl_any = |wl;

    // The single raised wordline connects its row to the bitlines.
    always_comb begin
        row_word = '0;
        for (int r = 0; r < ROWS; r++)
            if (wl[r]) row_word = row_word | cells[r];
    end

    // Bitlines: conditioned high (or driven for a write), then pulled by cells.
    always_ff @(posedge clk) begin
        if (rst) begin
            bl_q  <= '1;
            blb_q <= '1;
        end else if (cond_en) begin
            if (wr) begin
                bl_q  <= (drive & mask) | ~mask;
                blb_q <= (~drive & mask) | ~mask;
            end else begin
                bl_q  <= '1;
                blb_q <= '1;
            end
        end else if (wl_any) begin
            bl_q  <= bl_q & (row_word | held);
            blb_q <= blb_q & (~row_word | held);
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (wl[r] && wr) cells[r] <= (cells[r] & ~mask) | (bl_q & mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q  <= '0;
            swing_q  <= '0;
            wl_any_q <= 1'b0;
        end else begin
            wl_any_q <= wl_any;
            if (sense_en) sense_q <= gather_word(bl_q & ~blb_q, col_sel);
            if (cond_en) swing_q <= '0;
            else if (wl_any && swing_q != SW_W'(WL_CYCLES + 1)) swing_q <= swing_q + 1'b1;
        end
    end

    assign rdata = sense_q;

    // R8: read bitlines are equalized high at the moment the wordline rises
    p_equalized_read_r8: assert property (@(posedge clk) disable iff (rst)
        (wl_any && !wl_any_q && !wr) |-> ((&bl_q) && (&blb_q)));

    // R9: sense fires only once the wordline has been up long enough
    p_sense_after_swing_r9: assert property (@(posedge clk) disable iff (rst)
        sense_en |-> (swing_q >= SW_W'(WL_CYCLES)));
endmodule

// File: rtl/sram_fold_seq.sv
`timescale 1ns/1ps
module sram_fold_seq
    import sram_fold_pkg::*;
#(
    parameter int WL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata
);
    phase_e          phase;
    logic            accept, cond_en, wl_en, sense_en, done;
    access_t         acc_q;
    logic [ROWS-1:0] wl;

    sfa_phase_ctrl #(.WL_CYCLES(WL_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .phase(phase), .accept(accept),
        .cond_en(cond_en), .wl_en(wl_en), .sense_en(sense_en), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else if (accept) begin
            acc_q.we   <= we;
            acc_q.row  <= addr[ADDR_W-1:COL_SEL_W];
            acc_q.col  <= addr[COL_SEL_W-1:0];
            acc_q.data <= wdata;
        end
    end

    sfa_row_predec u_predec (
        .en(wl_en), .row(acc_q.row), .wl(wl)
    );

    sfa_bit_array #(.WL_CYCLES(WL_CYCLES)) u_array (
        .clk(clk), .rst(rst), .cond_en(cond_en), .wr(acc_q.we), .col_sel(acc_q.col),
        .wdata(acc_q.data), .wl(wl), .sense_en(sense_en), .rdata(rdata)
    );

    assign ready  = (phase == PH_IDLE);
    assign rvalid = done;

    // R7: one wordline in the wordline phase, none elsewhere
    p_wl_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WORDL) |-> $onehot(wl));
    p_wl_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WORDL) |-> (wl == '0));

    // R5: taking a request drops ready on the next cycle
    p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

    // R4: completion is a one-cycle pulse followed by idle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> (!rvalid && ready));
endmodule

// File: tb/sram_fold_seq_tb.sv
`timescale 1ns/1ps
module sram_fold_seq_tb;
    localparam int WL_CYC = 2;
    localparam int LAT    = WL_CYC + 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req, we;
    logic [10:0] addr;
    logic [15:0] wdata;
    logic        ready, rvalid;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    sram_fold_seq #(.WL_CYCLES(WL_CYC)) u_dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rvalid(rvalid), .rdata(rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input int a, input int seed);
        logic [31:0] x;
        x = a * 32'd40503 + seed * 32'd7919 + 32'h1357;
        return x[15:0] ^ x[31:16];
    endfunction

    task automatic access(input bit w, input int a, input logic [15:0] d,
                          input bit poke, output logic [15:0] got);
        int lat;
        @(negedge clk);
        req = 1'b1; we = w; addr = a[10:0]; wdata = d;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        if (poke) begin
            req = 1'b1; we = 1'b1; addr = a[10:0] ^ 11'h7FF; wdata = ~d;
        end else begin
            req = 1'b0;
        end
        check(ready == 1'b0, "R5 ready low while busy", int'(ready), 0);
        while (!rvalid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got = rdata;
        req = 1'b0;
        check(lat == LAT, "R4 completion latency", lat, LAT);
        @(negedge clk);
        check(rvalid == 1'b0 && ready == 1'b1, "R4 single pulse then idle",
              int'({rvalid, ready}), 1);
    endtask

    initial begin
        logic [15:0] got;
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b1 && rvalid == 1'b0, "R1 reset state", int'({ready, rvalid}), 2);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && rvalid == 1'b0, "R1 after reset", int'({ready, rvalid}), 2);

        // Fill every word; each write completion echoes the stored word (R3)
        for (int a = 0; a < 2048; a++) begin
            access(1'b1, a, pattern(a, 1), 1'b0, got);
            check(got == pattern(a, 1), "R3 write echo", int'(got), int'(pattern(a, 1)));
        end

        // Read every word: field split, predecode and bitline sequence (R2 R7 R8 R9 R10)
        for (int a = 0; a < 2048; a++) begin
            access(1'b0, a, 16'h0, 1'b0, got);
            check(got == pattern(a, 1), "R2/R7/R8/R9/R10 read sweep", int'(got),
                  int'(pattern(a, 1)));
        end

        // R6: rewrite one word of row 37, row-mates unchanged
        access(1'b1, 37*8 + 5, 16'hA5C3, 1'b0, got);
        for (int c = 0; c < 8; c++) begin
            access(1'b0, 37*8 + c, 16'h0, 1'b0, got);
            if (c == 5) check(got == 16'hA5C3, "R6 target word", int'(got), 'hA5C3);
            else check(got == pattern(37*8 + c, 1), "R6 row-mate kept", int'(got),
                       int'(pattern(37*8 + c, 1)));
        end

        // R5: a write poked on the pins while busy must be ignored
        access(1'b1, 100, 16'h3C69, 1'b1, got);
        access(1'b0, 100 ^ 2047, 16'h0, 1'b0, got);
        check(got == pattern(100 ^ 2047, 1), "R5 busy request ignored", int'(got),
              int'(pattern(100 ^ 2047, 1)));
        access(1'b0, 100, 16'h0, 1'b0, got);
        check(got == 16'h3C69, "R3 read after write", int'(got), 'h3C69);

        // R2 boundary addresses with a second pattern
        access(1'b1, 0, 16'hFFFF, 1'b0, got);
        access(1'b1, 2047, 16'h0000, 1'b0, got);
        access(1'b0, 0, 16'h0, 1'b0, got);
        check(got == 16'hFFFF, "R2 lowest address", int'(got), 'hFFFF);
        access(1'b0, 2047, 16'h0, 1'b0, got);
        check(got == 16'h0000, "R2 highest address", int'(got), 0);
        access(1'b0, 1, 16'h0, 1'b0, got);
        check(got == pattern(1, 1), "R6 neighbour of lowest", int'(got), int'(pattern(1, 1)));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule